// File: doc/BRIEF.md
# Indirect Dual-Channel Configuration Register Bank

This block is a small configuration bank on the host side of a storage controller, reached through a four-address I/O slave port. The bank holds two channels, and each channel has seven registers. Software does not address these registers directly. It first writes a byte-wide pointer that names a channel and an index. It then reads or writes a word-wide data port, and that access reaches the register the pointer names. When the pointer's auto-advance bit is set, the index steps forward after every data-port access, so a whole channel can be programmed as a burst of data writes.

Two more addresses complete the map. The first is one address that acts as a write-only chip-test register when written and as a read-only status register when read. The second holds the per-channel interrupt mask bits and shows the remaining status inputs. Every stored setting is driven onto parallel output ports. A FIFO-clear command is sent out as a one-clock pulse and is not stored.

Top module: `cfgbank_top`

## Requirements
- R1: While reset is active and after it, channel 0 index 0 holds 0x01F0 and index 4 holds 0x03F6. Channel 1 index 0 holds 0x0170 and index 4 holds 0x0376. On both channels index 1 holds 0x01, index 5 holds 0xF5 and index 6 holds 0xDE. The read-ahead state, the pointer, the chip-test bits and the mask bits are all zero.
- R2: Address 1 is the pointer. Write-data bits 2:0 set the index, bit 3 picks the channel (0 = channel 0, 1 = channel 1), and bit 7 enables auto-advance. A read returns these three fields at the same positions, and bits 6:4 read as 0.
- R3: Address 0 reads or writes register `index` of the channel the pointer picks. Indexes 0 and 4 are 16-bit. Indexes 1, 5 and 6 are 8-bit and sit in bits 7:0. A write never touches the other channel.
- R4: A read or write at address 0 while auto-advance is set moves the index on by one after that access. Index 6 moves to 0, and so does index 7. When auto-advance is clear, the index does not change.
- R5: At index 7 a data-port write changes no register, and a read returns 0.
- R6: Indexes 2 and 3 read as 0. Bits 7:0 of an index 2 write set bits 7:0 of the 10-bit read-ahead count. Bits 1:0 of an index 3 write set bits 9:8 of that count, and bit 7 of the same write sets the read-ahead enable.
- R7: Writing index 3 with bit 6 set raises that channel's FIFO-clear output for exactly the next clock cycle. The bit is not stored.
- R8: The index 1 byte of each channel appears on that channel's general-config output. Its fields are: bit 7 DMA enable, bit 6 drive reset, bit 5 ready-wait enable, bit 4 8-bit data port, bit 3 active-low interrupt, and bit 0 I/O enable.
- R9: A write to address 2 stores bit 1 as legacy mode and bit 0 as test mode. A read of address 2 returns the channel 0 bus-master interrupt input in bit 1 and the channel 0 interrupt input in bit 0.
- R10: A write to address 3 sets the mask bits from bits 1:0 (bit 1 for channel 1, bit 0 for channel 0) and ignores all other bits. A read returns the mask in bits 1:0, the channel 1 interrupt in bit 2, the channel 1 bus-master interrupt in bit 3, and the legacy-header input in bit 4.
- R11: Read data is 0 whenever the read strobe is low, and every undefined bit reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, never high together with wr_en |
| addr | input | 2 | Register address: 0 data, 1 pointer, 2 test/status, 3 mask |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational while rd_en is high |
| ch0_irq_i | input | 1 | Channel 0 interrupt status |
| ch0_bm_irq_i | input | 1 | Channel 0 bus-master interrupt status |
| ch1_irq_i | input | 1 | Channel 1 interrupt status |
| ch1_bm_irq_i | input | 1 | Channel 1 bus-master interrupt status |
| legacy_hdr_i | input | 1 | Legacy-header present flag |
| cmd_base_o | output | 2x16 | Command block base per channel |
| ctl_base_o | output | 2x16 | Control block base per channel |
| gen_cfg_o | output | 2x8 | General config byte per channel |
| ra_count_o | output | 2x10 | Read-ahead count per channel |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per channel |
| dtim_o | output | 2x8 | Data port timing byte per channel |
| ctim_o | output | 2x8 | Command/control timing byte per channel |
| irq_mask_o | output | 2 | Interrupt mask, bit per channel |
| legacy_mode_o | output | 1 | Legacy-compatible mode |
| test_mode_o | output | 1 | Test mode |

## Verification
The bench builds the block with its default parameters: a 16-bit data port, a 10-bit read-ahead count, and distinct reset words for the two channels. With these values, a readback can tell channel 0 and channel 1 apart from the first read after reset. The read-ahead count is split across two write-only indexes, and with a 10-bit count both of its halves and the split point are exercised. With seven real indexes and a three-bit field, the wrap from index 6 and the unused index 7 can be reached with a few pointer writes.

// File: rtl/cfgbank_pkg.sv
// Shared constants and helpers for the indirect configuration bank.
// Assumes a 3-bit index field and exactly two channels.
package cfgbank_pkg;
    localparam int NUM_CH = 2;
    localparam int IDX_W  = 3;

    // Register offsets on the slave port
    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_PTR  = 2'd1;
    localparam logic [1:0] OFS_TEST = 2'd2;
    localparam logic [1:0] OFS_MASK = 2'd3;

    // Per-channel register indexes
    localparam logic [IDX_W-1:0] IX_CMD  = 3'd0;
    localparam logic [IDX_W-1:0] IX_GEN  = 3'd1;
    localparam logic [IDX_W-1:0] IX_RALO = 3'd2;
    localparam logic [IDX_W-1:0] IX_RAHI = 3'd3;
    localparam logic [IDX_W-1:0] IX_CTL  = 3'd4;
    localparam logic [IDX_W-1:0] IX_DTIM = 3'd5;
    localparam logic [IDX_W-1:0] IX_CTIM = 3'd6;

    // Next index after a data access with auto-advance; 6 and 7 wrap to 0
    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] cur);
        return (cur >= IX_CTIM) ? '0 : cur + 1'b1;
    endfunction
endpackage

// File: rtl/cfgbank_ptr.sv
// Pointer register: index, channel select and auto-advance flag.
// Assumes a pointer write and a data-port access never share a cycle.
module cfgbank_ptr
    import cfgbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ai_in,
    input  logic             ch_in,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             data_acc,
    output logic [IDX_W-1:0] idx,
    output logic             ch,
    output logic             ai
);
    // Load from a pointer write, else step after a data access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            ch  <= 1'b0;
            ai  <= 1'b0;
        end else if (load) begin
            idx <= idx_in;
            ch  <= ch_in;
            ai  <= ai_in;
        end else if (data_acc && ai) begin
            idx <= next_idx(idx);
        end
    end
endmodule

// File: rtl/cfgbank_chan.sv
// One channel's set of seven registers behind the data port.
// Assumes we is already qualified with the channel select; index 7 is inert.
module cfgbank_chan
    import cfgbank_pkg::*;
#(
    parameter int             DW       = 16,
    parameter int             RA_W     = 10,
    parameter logic [DW-1:0]  CMD_RST  = 16'h01F0,
    parameter logic [DW-1:0]  CTL_RST  = 16'h03F6,
    parameter logic [7:0]     GEN_RST  = 8'h01,
    parameter logic [7:0]     DTIM_RST = 8'hF5,
    parameter logic [7:0]     CTIM_RST = 8'hDE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_word,
    output logic [DW-1:0]    cmd_base,
    output logic [DW-1:0]    ctl_base,
    output logic [7:0]       gen_cfg,
    output logic [RA_W-1:0]  ra_count,
    output logic             ra_en,
    output logic             fifo_clr,
    output logic [7:0]       dtim,
    output logic [7:0]       ctim
);
    localparam int RA_HI_W = RA_W - 8;

    logic [DW-1:0]      cmd_q, ctl_q;
    logic [7:0]         gen_q, ralo_q, dtim_q, ctim_q;
    logic [RA_HI_W-1:0] rahi_q;
    logic               raen_q, fifo_q;

    // Register writes by index; FIFO clear lives for one cycle only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_RST;
            ctl_q  <= CTL_RST;
            gen_q  <= GEN_RST;
            ralo_q <= '0;
            rahi_q <= '0;
            raen_q <= 1'b0;
            dtim_q <= DTIM_RST;
            ctim_q <= CTIM_RST;
            fifo_q <= 1'b0;
        end else begin
            fifo_q <= 1'b0;
            if (we) begin
                case (idx)
                    IX_CMD:  cmd_q  <= wdata;
                    IX_GEN:  gen_q  <= wdata[7:0];
                    IX_RALO: ralo_q <= wdata[7:0];
                    IX_RAHI: begin
                        raen_q <= wdata[7];
                        fifo_q <= wdata[6];
                        rahi_q <= wdata[RA_HI_W-1:0];
                    end
                    IX_CTL:  ctl_q  <= wdata;
                    IX_DTIM: dtim_q <= wdata[7:0];
                    IX_CTIM: ctim_q <= wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    // Readback mux; write-only and unused indexes return zero
    always_comb begin
        rd_word = '0;
        case (idx)
            IX_CMD:  rd_word       = cmd_q;
            IX_GEN:  rd_word[7:0]  = gen_q;
            IX_CTL:  rd_word       = ctl_q;
            IX_DTIM: rd_word[7:0]  = dtim_q;
            IX_CTIM: rd_word[7:0]  = ctim_q;
            default: rd_word       = '0;
        endcase
    end

    assign cmd_base = cmd_q;
    assign ctl_base = ctl_q;
    assign gen_cfg  = gen_q;
    assign ra_count = {rahi_q, ralo_q};
    assign ra_en    = raen_q;
    assign fifo_clr = fifo_q;
    assign dtim     = dtim_q;
    assign ctim     = ctim_q;
endmodule

// File: rtl/cfgbank_glob.sv
// Chip-wide bits: chip-test mode bits and per-channel interrupt masks.
// Assumes the caller decodes the address; only the low two data bits matter.
module cfgbank_glob (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_test,
    input  logic       wr_mask,
    input  logic [1:0] wbits,
    output logic       legacy_mode,
    output logic       test_mode,
    output logic [1:0] irq_mask
);
    // Capture test-mode bits and mask bits on their own writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_mode <= 1'b0;
            test_mode   <= 1'b0;
            irq_mask    <= 2'b00;
        end else begin
            if (wr_test) begin
                legacy_mode <= wbits[1];
                test_mode   <= wbits[0];
            end
            if (wr_mask) irq_mask <= wbits;
        end
    end
endmodule

// File: rtl/cfgbank_top.sv
// Indirect dual-channel configuration bank on a four-address slave port.
// Assumes wr_en and rd_en are never high together; rdata is combinational.
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int              DW           = 16,
    parameter int              RA_W         = 10,
    parameter logic [DW-1:0]   CMD_BASE_PRI = 16'h01F0,
    parameter logic [DW-1:0]   CMD_BASE_SEC = 16'h0170,
    parameter logic [DW-1:0]   CTL_BASE_PRI = 16'h03F6,
    parameter logic [DW-1:0]   CTL_BASE_SEC = 16'h0376,
    parameter logic [7:0]      GEN_DEFAULT  = 8'h01,
    parameter logic [7:0]      DTIM_DEFAULT = 8'hF5,
    parameter logic [7:0]      CTIM_DEFAULT = 8'hDE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [1:0]                 addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    input  logic                       ch0_irq_i,
    input  logic                       ch0_bm_irq_i,
    input  logic                       ch1_irq_i,
    input  logic                       ch1_bm_irq_i,
    input  logic                       legacy_hdr_i,
    output logic [NUM_CH-1:0][DW-1:0]  cmd_base_o,
    output logic [NUM_CH-1:0][DW-1:0]  ctl_base_o,
    output logic [NUM_CH-1:0][7:0]     gen_cfg_o,
    output logic [NUM_CH-1:0][RA_W-1:0] ra_count_o,
    output logic [NUM_CH-1:0]          ra_en_o,
    output logic [NUM_CH-1:0]          fifo_clr_o,
    output logic [NUM_CH-1:0][7:0]     dtim_o,
    output logic [NUM_CH-1:0][7:0]     ctim_o,
    output logic [1:0]                 irq_mask_o,
    output logic                       legacy_mode_o,
    output logic                       test_mode_o
);
    logic [IDX_W-1:0]           ptr_idx;
    logic                       ptr_ch;
    logic                       ptr_ai;
    logic                       data_acc;
    logic [NUM_CH-1:0][DW-1:0]  chan_rd;

    assign data_acc = (wr_en || rd_en) && (addr == OFS_DATA);

    cfgbank_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && (addr == OFS_PTR)),
        .ai_in    (wdata[7]),
        .ch_in    (wdata[3]),
        .idx_in   (wdata[IDX_W-1:0]),
        .data_acc (data_acc),
        .idx      (ptr_idx),
        .ch       (ptr_ch),
        .ai       (ptr_ai)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        cfgbank_chan #(
            .DW       (DW),
            .RA_W     (RA_W),
            .CMD_RST  ((g == 0) ? CMD_BASE_PRI : CMD_BASE_SEC),
            .CTL_RST  ((g == 0) ? CTL_BASE_PRI : CTL_BASE_SEC),
            .GEN_RST  (GEN_DEFAULT),
            .DTIM_RST (DTIM_DEFAULT),
            .CTIM_RST (CTIM_DEFAULT)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (wr_en && (addr == OFS_DATA) && (ptr_ch == 1'(g))),
            .idx      (ptr_idx),
            .wdata    (wdata),
            .rd_word  (chan_rd[g]),
            .cmd_base (cmd_base_o[g]),
            .ctl_base (ctl_base_o[g]),
            .gen_cfg  (gen_cfg_o[g]),
            .ra_count (ra_count_o[g]),
            .ra_en    (ra_en_o[g]),
            .fifo_clr (fifo_clr_o[g]),
            .dtim     (dtim_o[g]),
            .ctim     (ctim_o[g])
        );
    end

    cfgbank_glob u_glob (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_test     (wr_en && (addr == OFS_TEST)),
        .wr_mask     (wr_en && (addr == OFS_MASK)),
        .wbits       (wdata[1:0]),
        .legacy_mode (legacy_mode_o),
        .test_mode   (test_mode_o),
        .irq_mask    (irq_mask_o)
    );

    // Read decode; one address shows status instead of the test register
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_DATA: rdata      = chan_rd[ptr_ch];
                OFS_PTR:  rdata[7:0] = {ptr_ai, 3'b000, ptr_ch, ptr_idx};
                OFS_TEST: rdata[1:0] = {ch0_bm_irq_i, ch0_irq_i};
                default:  rdata[4:0] = {legacy_hdr_i, ch1_bm_irq_i, ch1_irq_i, irq_mask_o};
            endcase
        end
    end
endmodule

// File: rtl/cfgbank_chk.sv
// Property checker for cfgbank_top, attached by bind below.
// Assumes the top's internal pointer fields are visible at the bind scope.
module cfgbank_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [1:0]    addr,
    input logic          wbit6,
    input logic [DW-1:0] rdata,
    input logic [2:0]    ptr_idx,
    input logic          ptr_ch,
    input logic          ptr_ai,
    input logic [1:0]    fifo_clr_o,
    input logic [1:0]    irq_mask_o,
    input logic          ch0_irq_i,
    input logic          ch0_bm_irq_i
);
    // R4: index 6 wraps to 0 after a data access with auto-advance
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && addr == 2'd0 && ptr_ai && ptr_idx == 3'd6) |=> (ptr_idx == 3'd0));

    // R4: without a data access or pointer write the index holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !((wr_en || rd_en) && addr == 2'd0) && !(wr_en && addr == 2'd1) |=> $stable(ptr_idx));

    // R5: index 7 reads zero
    a_r5_idx7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && ptr_idx == 3'd7) |-> (rdata == '0));

    // R6: write-only indexes read zero
    a_r6_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && (ptr_idx == 3'd2 || ptr_idx == 3'd3)) |-> (rdata == '0));

    // R9: status read reflects the channel 0 interrupt inputs
    a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2) |-> (rdata == {{(DW-2){1'b0}}, ch0_bm_irq_i, ch0_irq_i}));

    // R10: mask only moves on a write to its own address
    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd3) |=> $stable(irq_mask_o));

    // R11: no read strobe means zero read data
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    for (genvar g = 0; g < 2; g++) begin : g_fifo
        // R7: a pulse only follows a matching index 3 write
        a_r7_fifo_src: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_clr_o[g] |-> $past(wr_en && addr == 2'd0 && ptr_ch == 1'(g) && ptr_idx == 3'd3 && wbit6));
        // R7: the pulse is not held without a new command
        a_r7_fifo_once: assert property (@(posedge clk) disable iff (!rst_n)
            (fifo_clr_o[g] && !(wr_en && addr == 2'd0 && ptr_ch == 1'(g) && ptr_idx == 3'd3 && wbit6))
            |=> !fifo_clr_o[g]);
    end
endmodule

bind cfgbank_top cfgbank_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wbit6        (wdata[6]),
    .rdata        (rdata),
    .ptr_idx      (ptr_idx),
    .ptr_ch       (ptr_ch),
    .ptr_ai       (ptr_ai),
    .fifo_clr_o   (fifo_clr_o),
    .irq_mask_o   (irq_mask_o),
    .ch0_irq_i    (ch0_irq_i),
    .ch0_bm_irq_i (ch0_bm_irq_i)
);

// File: tb/tb_cfgbank_top.sv
`timescale 1ns/1ps
// Bench for cfgbank_top: behavioural model stepped per clock, all outputs compared.
module tb_cfgbank_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_wr = 0, i_rd = 0;
    logic [1:0]  i_addr = 0;
    logic [15:0] i_wd = 0;
    logic s0 = 0, s0b = 0, s1 = 0, s1b = 0, slh = 0;
    logic [15:0] rdata;
    logic [1:0][15:0] cmd_base_o, ctl_base_o;
    logic [1:0][7:0]  gen_cfg_o, dtim_o, ctim_o;
    logic [1:0][9:0]  ra_count_o;
    logic [1:0] ra_en_o, fifo_clr_o, irq_mask_o;
    logic legacy_mode_o, test_mode_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string tag_ovr = "";

    // model state
    int m_cmd[2], m_ctl[2], m_gen[2], m_ralo[2], m_rahi[2], m_raen[2];
    int m_dt[2], m_ct[2], m_fifo[2];
    int m_idx, m_ch, m_ai, m_leg, m_tst, m_mask;

    always #2.5 clk = ~clk;

    cfgbank_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(i_wr), .rd_en(i_rd), .addr(i_addr),
        .wdata(i_wd), .rdata(rdata), .ch0_irq_i(s0), .ch0_bm_irq_i(s0b),
        .ch1_irq_i(s1), .ch1_bm_irq_i(s1b), .legacy_hdr_i(slh),
        .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
        .ra_count_o(ra_count_o), .ra_en_o(ra_en_o), .fifo_clr_o(fifo_clr_o),
        .dtim_o(dtim_o), .ctim_o(ctim_o), .irq_mask_o(irq_mask_o),
        .legacy_mode_o(legacy_mode_o), .test_mode_o(test_mode_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_cmd = '{32'h1F0, 32'h170};
        m_ctl = '{32'h3F6, 32'h376};
        for (int c = 0; c < 2; c++) begin
            m_gen[c] = 1; m_ralo[c] = 0; m_rahi[c] = 0; m_raen[c] = 0;
            m_dt[c] = 'hF5; m_ct[c] = 'hDE; m_fifo[c] = 0;
        end
        m_idx = 0; m_ch = 0; m_ai = 0; m_leg = 0; m_tst = 0; m_mask = 0;
    endfunction

    function automatic int exp_rd();
        int d = i_wd;
        if (!i_rd) return 0;
        case (i_addr)
            2'd0: case (m_idx)
                0: return m_cmd[m_ch];
                1: return m_gen[m_ch];
                4: return m_ctl[m_ch];
                5: return m_dt[m_ch];
                6: return m_ct[m_ch];
                default: return 0;
            endcase
            2'd1: return m_ai * 128 + m_ch * 8 + m_idx;
            2'd2: return s0b * 2 + s0;
            default: return slh * 16 + s1b * 8 + s1 * 4 + m_mask + (d & 0);
        endcase
    endfunction

    function automatic string rd_tag();
        if (tag_ovr != "") return tag_ovr;
        if (!i_rd) return "R11";
        case (i_addr)
            2'd0: return (m_idx == 7) ? "R5" : (m_idx == 2 || m_idx == 3) ? "R6" : "R3";
            2'd1: return "R2";
            2'd2: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare_all();
        string rt = rst_n ? "R3" : "R1";
        chk(rd_tag(), "rdata", int'(rdata), exp_rd());
        for (int c = 0; c < 2; c++) begin
            chk(rt, "cmd_base", int'(cmd_base_o[c]), m_cmd[c]);
            chk(rt, "ctl_base", int'(ctl_base_o[c]), m_ctl[c]);
            chk(rt, "dtim", int'(dtim_o[c]), m_dt[c]);
            chk(rt, "ctim", int'(ctim_o[c]), m_ct[c]);
            chk(rst_n ? "R8" : "R1", "gen_cfg", int'(gen_cfg_o[c]), m_gen[c]);
            chk("R6", "ra_count", int'(ra_count_o[c]), m_rahi[c] * 256 + m_ralo[c]);
            chk("R6", "ra_en", int'(ra_en_o[c]), m_raen[c]);
            chk("R7", "fifo_clr", int'(fifo_clr_o[c]), m_fifo[c]);
        end
        chk("R9", "legacy_mode", int'(legacy_mode_o), m_leg);
        chk("R9", "test_mode", int'(test_mode_o), m_tst);
        chk("R10", "irq_mask", int'(irq_mask_o), m_mask);
    endtask

    task automatic model_apply();
        int d = i_wd;
        if (!rst_n) begin model_reset(); return; end
        m_fifo[0] = 0; m_fifo[1] = 0;
        if (i_wr) begin
            case (i_addr)
                2'd0: case (m_idx)
                    0: m_cmd[m_ch] = d;
                    1: m_gen[m_ch] = d % 256;
                    2: m_ralo[m_ch] = d % 256;
                    3: begin
                        m_raen[m_ch] = (d / 128) % 2;
                        m_fifo[m_ch] = (d / 64) % 2;
                        m_rahi[m_ch] = d % 4;
                    end
                    4: m_ctl[m_ch] = d;
                    5: m_dt[m_ch] = d % 256;
                    6: m_ct[m_ch] = d % 256;
                    default: ;
                endcase
                2'd1: begin m_idx = d % 8; m_ch = (d / 8) % 2; m_ai = (d / 128) % 2; end
                2'd2: begin m_leg = (d / 2) % 2; m_tst = d % 2; end
                default: m_mask = d % 4;
            endcase
        end
        if ((i_wr || i_rd) && i_addr == 2'd0 && m_ai == 1 && !(i_wr && i_addr == 2'd1))
            m_idx = (m_idx >= 6) ? 0 : m_idx + 1;
    endtask

    task automatic step(input logic w, input logic r, input logic [1:0] a, input logic [15:0] d);
        i_wr = w; i_rd = r; i_addr = a; i_wd = d;
        @(negedge clk);
        compare_all();
        @(posedge clk);
        model_apply();
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d); step(1, 0, a, d); endtask
    task automatic rd(input logic [1:0] a); step(0, 1, a, 16'h0); endtask
    task automatic idle(); step(0, 0, 2'd0, 16'h0); endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state held during reset
        repeat (3) idle();
        rst_n = 1'b1;
        // R1: reset values readable on both channels, no auto-advance
        tag_ovr = "R1";
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 8; i++) begin
                wr(2'd1, 16'(c * 8 + i));
                rd(2'd0);
            end
        tag_ovr = "";
        // R2: pointer fields, bits 6:4 dropped
        wr(2'd1, 16'h00FF); rd(2'd1);
        wr(2'd1, 16'h0035); rd(2'd1);
        // R3/R6/R7/R8/R4: burst program channel 0 with auto-advance
        wr(2'd1, 16'h0080);
        wr(2'd0, 16'h1234); wr(2'd0, 16'h00A5); wr(2'd0, 16'h003C);
        wr(2'd0, 16'h00C1); wr(2'd0, 16'hBABC); wr(2'd0, 16'h0009);
        wr(2'd0, 16'h0077);
        tag_ovr = "R4"; rd(2'd1); tag_ovr = "";
        // R3: read back channel 0 through auto-advance reads
        repeat (8) rd(2'd0);
        // R4: wrap from 6 on channel 1, and 7 to 0
        wr(2'd1, 16'h008E); rd(2'd0);
        tag_ovr = "R4"; rd(2'd1); tag_ovr = "";
        wr(2'd1, 16'h0087); rd(2'd0);
        tag_ovr = "R4"; rd(2'd1); tag_ovr = "";
        // R4: no advance when flag clear
        wr(2'd1, 16'h0004); rd(2'd0); wr(2'd0, 16'h5555);
        tag_ovr = "R4"; rd(2'd1); tag_ovr = "";
        // R5: index 7 writes nothing, reads zero
        wr(2'd1, 16'h000F); wr(2'd0, 16'hFFFF); rd(2'd0);
        wr(2'd1, 16'h0007); wr(2'd0, 16'hFFFF); rd(2'd0);
        // R6/R7: channel 1 read-ahead, back-to-back FIFO clears
        wr(2'd1, 16'h000A); wr(2'd0, 16'h00FF); rd(2'd0);
        wr(2'd1, 16'h000B); wr(2'd0, 16'h0043); wr(2'd0, 16'h0040);
        wr(2'd0, 16'h0002); idle(); rd(2'd0);
        // R9: chip-test write, status read
        wr(2'd2, 16'h0083); idle();
        s0 = 1; rd(2'd2); s0b = 1; s0 = 0; rd(2'd2);
        wr(2'd2, 16'h0081); rd(2'd2);
        // R10: mask bits, other bits ignored, status inputs shown
        wr(2'd3, 16'hFFFE); rd(2'd3);
        s1 = 1; slh = 1; rd(2'd3); s1b = 1; s1 = 0; rd(2'd3);
        wr(2'd3, 16'h0001); rd(2'd3);
        // R8: general config fields on channel 1
        wr(2'd1, 16'h0009); wr(2'd0, 16'h00F8); rd(2'd0);
        // R11: idle read data
        repeat (3) idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule